// File: doc/BRIEF.md
# Drift-Compensated Precision Time Counter

This block keeps a 64-bit nanosecond clock for IEEE 1588 time stamping. It runs on one reference clock. On every reference cycle a 32-bit phase accumulator adds a programmable addend. Each carry out of the accumulator is one nominal tick, and each tick advances the time counter by a programmable integer tick period in nanoseconds. The addend sets the nominal tick rate. For a reference-to-nominal frequency ratio above 1.0 it is ceil(2^32 / ratio), and small changes to it trim frequency drift.

Three outputs are derived from the tick stream. A prescaler makes a one-cycle output clock enable once every `prescale` ticks. Two independent fixed-interval pulse generators count down by the tick period on each tick. The interval value is programmed one tick period short of the full interval, which is prescale × tick period × divider − tick period, and is 0x3B9AC9F6 for a 1 Hz pulse at a 10 ns tick. Each pulse is held for one prescaled period. A 2-bit clock-select field is also kept for the clock multiplexer outside the block. Its codes are 0 for the external precision oscillator, 1 for the system clock, 2 for the port-1 transmit clock and 3 for the real-time-clock input.

Configuration uses a plain single-cycle write port with an address and 32 bits of data. There is no stream traffic, so there is no valid/ready handshake.

Top module: `ptp_timer_core`

## Requirements
- R1: After reset, `time_ns` is 0, `clk_sel` is 1, the addend is 0 so `tick` stays low, and `out_clk_en`, `pulse1` and `pulse2` are low.
- R2: In each cycle the accumulator adds the addend modulo 2^32, and `tick` is high in exactly the cycles where the sum reaches 2^32. Starting from an accumulator of 0, N cycles produce floor(N × addend / 2^32) ticks.
- R3: `time_ns` grows by the tick period (address 1, bits [7:0]) at the clock edge that ends each tick cycle. It does not change in any other cycle unless software writes it.
- R4: A write to address 5 (bits [31:0]) or address 6 (bits [63:32]) loads that half of `time_ns` one cycle after the write edge. In that cycle the load takes priority over a tick.
- R5: `out_clk_en` is a one-cycle pulse that follows every `prescale`-th tick. The prescale is at address 2, bits [15:0], and a value of 0 acts as 1.
- R6: After a restart, a pulse generator with interval value V (address 3 for `pulse1`, address 4 for `pulse2`) rises on tick number V / period + 1, and then again after every further V / period + 1 ticks.
- R7: Each pulse stays high for `prescale` ticks.
- R8: Any write to address 3, 4, 5 or 6 restarts both pulse generators in the same cycle, and clears any pulse in progress, so the two stay phase-aligned.
- R9: `clk_sel` is written through address 7, bits [1:0], with codes 0 external oscillator, 1 system clock, 2 port-1 transmit clock, 3 RTC input. It has no effect inside the block.
- R10: Writes to addresses 8 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| time_ns | output | 64 | Current time in nanoseconds |
| tick | output | 1 | Accumulator carry in this cycle |
| out_clk_en | output | 1 | Prescaled output clock enable |
| pulse1 | output | 1 | First fixed-interval pulse |
| pulse2 | output | 1 | Second fixed-interval pulse |
| clk_sel | output | 2 | Reference clock select field |

## Verification
The bench sweeps addend and period pairs, including addend 1, all ones, one half and the 0x999999A4 example. It compares the tick count and the final time with floor(N × addend / 2^32) × period. A design that ticked on the wrong carry or dropped the wrap-around would miss these by one or more periods. The pulse tests use interval values that are one period short. A generator that counted to the full interval, or reloaded one tick late, would move the 12- and 20-cycle spacings and the pulse width. A restart in mid-run checks the fixed 8-cycle offset between the two generators, which exposes a restart applied to only one of them. A prescale of 0, time loads made together with ticks, and writes to unmapped addresses cover the remaining boundaries.

// File: rtl/ptp_timer_pkg.sv
package ptp_timer_pkg;
  typedef enum logic [3:0] {
    A_ADDEND   = 4'd0,
    A_PERIOD   = 4'd1,
    A_PRESCALE = 4'd2,
    A_IVAL1    = 4'd3,
    A_IVAL2    = 4'd4,
    A_TIME_LO  = 4'd5,
    A_TIME_HI  = 4'd6,
    A_CTRL     = 4'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_EXT_OSC = 2'd0,
    SRC_SYS_CLK = 2'd1,
    SRC_TX_CLK  = 2'd2,
    SRC_RTC     = 2'd3
  } clk_src_e;
endpackage

// File: rtl/ptp_regfile.sv
module ptp_regfile
  import ptp_timer_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int ACC_W     = 32,
  parameter int TICK_W    = 8,
  parameter int PRSC_W    = 16,
  parameter int IV_W      = 32,
  parameter int NUM_PULSE = 2,
  parameter logic [TICK_W-1:0] RST_PERIOD = 10,
  parameter logic [PRSC_W-1:0] RST_PRSC   = 100,
  parameter logic [IV_W-1:0]   RST_IVAL   = 32'h3B9AC9F6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [ACC_W-1:0]     addend,
  output logic [TICK_W-1:0]    period,
  output logic [PRSC_W-1:0]    prescale,
  output logic [IV_W-1:0]      ival [NUM_PULSE],
  output logic [1:0]           clk_sel,
  output logic                 ld_lo,
  output logic                 ld_hi,
  output logic [DATA_W-1:0]    ld_data,
  output logic                 restart
);
  logic hit_ival, hit_time;

  always_comb begin
    hit_ival = 1'b0;
    for (int k = 0; k < NUM_PULSE; k++)
      if (wr_addr == ADDR_W'(int'(A_IVAL1) + k)) hit_ival = 1'b1;
    hit_time = (wr_addr == ADDR_W'(A_TIME_LO)) || (wr_addr == ADDR_W'(A_TIME_HI));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addend   <= '0;
      period   <= RST_PERIOD;
      prescale <= RST_PRSC;
      clk_sel  <= SRC_SYS_CLK;
      ld_lo    <= 1'b0;
      ld_hi    <= 1'b0;
      ld_data  <= '0;
      restart  <= 1'b0;
    end else begin
      ld_lo   <= wr_en && (wr_addr == ADDR_W'(A_TIME_LO));
      ld_hi   <= wr_en && (wr_addr == ADDR_W'(A_TIME_HI));
      restart <= wr_en && (hit_ival || hit_time);
      if (wr_en) begin
        ld_data <= wr_data;
        case (wr_addr)
          ADDR_W'(A_ADDEND):   addend   <= wr_data[ACC_W-1:0];
          ADDR_W'(A_PERIOD):   period   <= wr_data[TICK_W-1:0];
          ADDR_W'(A_PRESCALE): prescale <= wr_data[PRSC_W-1:0];
          ADDR_W'(A_CTRL):     clk_sel  <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_ival
    always_ff @(posedge clk) begin
      if (!rst_n) ival[g] <= RST_IVAL;
      else if (wr_en && wr_addr == ADDR_W'(int'(A_IVAL1) + g)) ival[g] <= wr_data[IV_W-1:0];
    end
  end

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(A_CTRL)) |=> $stable(clk_sel));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_W'(A_CTRL)) |=> ($stable(addend) && $stable(period) && $stable(prescale)));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int ACC_W  = 32,
  parameter int TIME_W = 64,
  parameter int TICK_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  addend,
  input  logic [TICK_W-1:0] period,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] ld_data,
  output logic              carry,
  output logic [TIME_W-1:0] time_ns
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, addend};
  assign carry = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_ns <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) time_ns[DATA_W-1:0]      <= ld_data;
      if (ld_hi) time_ns[TIME_W-1:DATA_W] <= ld_data[HI_W-1:0];
    end else if (carry) begin
      time_ns <= time_ns + TIME_W'(period);
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry && !ld_lo && !ld_hi) |=> $stable(time_ns));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !ld_lo && !ld_hi) |=> (time_ns - $past(time_ns)) == TIME_W'($past(period)));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> time_ns[DATA_W-1:0] == $past(ld_data));
endmodule

// File: rtl/ptp_prescaler.sv
module ptp_prescaler #(
  parameter int PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carry,
  input  logic [PRSC_W-1:0] prescale,
  output logic              out_en
);
  logic [PRSC_W-1:0] cnt;
  logic [PRSC_W-1:0] last;
  logic              wrap;

  assign last = (prescale == '0) ? '0 : prescale - 1'b1;
  assign wrap = (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      out_en <= 1'b0;
    end else begin
      out_en <= carry && wrap;
      if (carry) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  p_oen_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(carry));
  p_oen_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && prescale > 1 && $stable(prescale)) |=> !out_en);
endmodule

// File: rtl/ptp_pulse_gen.sv
module ptp_pulse_gen #(
  parameter int TICK_W = 8,
  parameter int PRSC_W = 16,
  parameter int IV_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carry,
  input  logic              restart,
  input  logic [TICK_W-1:0] period,
  input  logic [PRSC_W-1:0] prescale,
  input  logic [IV_W-1:0]   ival,
  output logic              pulse
);
  logic [IV_W-1:0]   down;
  logic [PRSC_W-1:0] width;
  logic [PRSC_W-1:0] width_load;
  logic              fire;

  assign fire       = carry && (down < IV_W'(period));
  assign width_load = (prescale == '0) ? PRSC_W'(1) : prescale;
  assign pulse      = (width != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      down  <= '0;
      width <= '0;
    end else if (restart) begin
      down  <= ival;
      width <= '0;
    end else if (carry) begin
      down  <= fire ? ival : down - IV_W'(period);
      if (fire)            width <= width_load;
      else if (width != 0) width <= width - 1'b1;
    end
  end

  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(carry));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart) |=> down == $past(ival));
  p_fall_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !carry && !restart) |=> pulse);
  p_restart_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !pulse);
endmodule

// File: rtl/ptp_timer_core.sv
module ptp_timer_core
  import ptp_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int ACC_W  = 32,
  parameter int TIME_W = 64,
  parameter int TICK_W = 8,
  parameter int PRSC_W = 16,
  parameter int IV_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [TIME_W-1:0] time_ns,
  output logic              tick,
  output logic              out_clk_en,
  output logic              pulse1,
  output logic              pulse2,
  output logic [1:0]        clk_sel
);
  localparam int NUM_PULSE = 2;

  logic [ACC_W-1:0]  addend;
  logic [TICK_W-1:0] period;
  logic [PRSC_W-1:0] prescale;
  logic [IV_W-1:0]   ival [NUM_PULSE];
  logic              ld_lo, ld_hi, restart;
  logic [DATA_W-1:0] ld_data;
  logic [NUM_PULSE-1:0] pulses;

  ptp_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .TICK_W(TICK_W),
    .PRSC_W(PRSC_W), .IV_W(IV_W), .NUM_PULSE(NUM_PULSE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addend(addend), .period(period), .prescale(prescale), .ival(ival),
    .clk_sel(clk_sel), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
    .restart(restart)
  );

  ptp_time_counter #(
    .ACC_W(ACC_W), .TIME_W(TIME_W), .TICK_W(TICK_W), .DATA_W(DATA_W)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .addend(addend), .period(period),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
    .carry(tick), .time_ns(time_ns)
  );

  ptp_prescaler #(.PRSC_W(PRSC_W)) u_prsc (
    .clk(clk), .rst_n(rst_n), .carry(tick), .prescale(prescale), .out_en(out_clk_en)
  );

  for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
    ptp_pulse_gen #(.TICK_W(TICK_W), .PRSC_W(PRSC_W), .IV_W(IV_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .carry(tick), .restart(restart),
      .period(period), .prescale(prescale), .ival(ival[g]), .pulse(pulses[g])
    );
  end

  assign pulse1 = pulses[0];
  assign pulse2 = pulses[1];

  p_reset_sel_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> clk_sel == SRC_SYS_CLK);
endmodule

// File: tb/tb_ptp_timer_core.sv
`timescale 1ns/1ps
module tb_ptp_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_ns;
  logic        tick, out_clk_en, pulse1, pulse2;
  logic [1:0]  clk_sel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic log_en = 1'b0;
  int r1 [8]; int f1 [8]; int r2 [8]; int ro [8];
  int n1 = 0, nf1 = 0, n2 = 0, no = 0;
  logic p1q = 1'b0, p2q = 1'b0;

  always #2 clk = ~clk;

  ptp_timer_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .time_ns(time_ns), .tick(tick), .out_clk_en(out_clk_en),
    .pulse1(pulse1), .pulse2(pulse2), .clk_sel(clk_sel)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!log_en) begin
      n1 = 0; nf1 = 0; n2 = 0; no = 0;
    end else begin
      if (pulse1 && !p1q && n1 < 8) begin r1[n1] = cyc; n1++; end
      if (!pulse1 && p1q && nf1 < 8) begin f1[nf1] = cyc; nf1++; end
      if (pulse2 && !p2q && n2 < 8) begin r2[n2] = cyc; n2++; end
      if (out_clk_en && no < 8) begin ro[no] = cyc; no++; end
    end
    p1q = pulse1;
    p2q = pulse2;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2/R3 sweep: N cycles from acc=0 give floor(N*A/2^32) ticks
  task automatic sweep(input logic [31:0] a, input logic [7:0] p, input int n);
    longint unsigned exp_t;
    int cnt;
    do_reset();
    wr(4'd1, {24'd0, p});
    wr(4'd0, a);
    cnt = 0;
    for (int j = 0; j < n; j++) begin
      if (tick) cnt++;
      @(negedge clk);
    end
    exp_t = (longint'(n) * longint'(a)) >> 32;
    check("R2 tick count", 64'(cnt), exp_t);
    check("R3 time after ticks", time_ns, exp_t * p);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    idle(5);
    // R1 reset state
    check("R1 time", time_ns, 64'd0);
    check("R1 clk_sel", 64'(clk_sel), 64'd1);
    check("R1 outputs low", {60'd0, tick, out_clk_en, pulse1, pulse2}, 64'd0);

    // R2 / R3 sweep over addend and period pairs
    sweep(32'h8000_0000, 8'd10, 200);
    sweep(32'h4000_0000, 8'd8, 200);
    sweep(32'h9999_99A4, 8'd10, 200);
    sweep(32'hFFFF_FFFF, 8'd1, 200);
    sweep(32'h0000_0001, 8'd255, 200);
    sweep(32'h5555_5556, 8'd3, 301);

    // R4 time load, with no ticks, and then over a running tick
    do_reset();
    wr(4'd6, 32'd5);
    wr(4'd5, 32'd7);
    idle(2);
    check("R4 time load", time_ns, {32'd5, 32'd7});
    wr(4'd1, 32'd10);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd5, 32'd1000);
    wr(4'd0, 32'd0);
    idle(3);
    check("R4 load beats tick", time_ns, {32'd5, 32'd1000} + 64'd10);

    // R9 clock select field
    wr(4'd7, 32'd2);
    idle(1);
    check("R9 clk_sel write", 64'(clk_sel), 64'd2);

    // R10 unmapped writes
    for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    idle(5);
    check("R10 time untouched", time_ns, {32'd5, 32'd1000} + 64'd10);
    check("R10 clk_sel untouched", 64'(clk_sel), 64'd2);
    check("R10 no ticks", 64'(tick), 64'd0);

    // R5-R8 pulses: period 10, prescale 2, tick every 2 cycles
    do_reset();
    wr(4'd1, 32'd10);
    wr(4'd2, 32'd2);
    wr(4'd3, 32'd50);
    wr(4'd4, 32'd90);
    log_en = 1'b1;
    wr(4'd0, 32'h8000_0000);
    idle(100);
    check("R6 pulse1 spacing", 64'(r1[1] - r1[0]), 64'd12);
    check("R6 pulse1 spacing 2", 64'(r1[2] - r1[1]), 64'd12);
    check("R6 pulse2 spacing", 64'(r2[1] - r2[0]), 64'd20);
    check("R7 pulse width", 64'(f1[0] - r1[0]), 64'd4);
    check("R8 first offset", 64'(r2[0] - r1[0]), 64'd8);
    check("R5 out_en spacing", 64'(ro[1] - ro[0]), 64'd4);
    check("R5 out_en spacing 2", 64'(ro[2] - ro[1]), 64'd4);
    log_en = 1'b0;

    // R8 restart in mid-run realigns both generators
    idle(7);
    wr(4'd3, 32'd50);
    idle(3);
    log_en = 1'b1;
    idle(60);
    check("R8 offset after restart", 64'(r2[0] - r1[0]), 64'd8);
    log_en = 1'b0;

    // R5 prescale 0 acts as 1, R7 width one tick
    wr(4'd2, 32'd0);
    wr(4'd3, 32'd50);
    idle(3);
    log_en = 1'b1;
    idle(60);
    check("R5 prescale zero", 64'(ro[1] - ro[0]), 64'd2);
    check("R7 width prescale zero", 64'(f1[0] - r1[0]), 64'd2);
    log_en = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule